// File: doc/BRIEF.md
# EEPROM Write-Start Controller

This block models the device-side logic that decides when a parallel EEPROM begins internal programming. A fast clock samples the active-low chip-enable and write-enable inputs, together with the address and data buses. A write-enable low pulse counts as a byte load only if it lasted long enough. Each accepted load stores its data byte in a page buffer, in the slot chosen by the low address bits. The load also starts a byte-load timer.

A new falling write-enable edge stops the timer, and the next rising edge restarts it from zero. When the timer runs out, the block raises a one-cycle commit strobe. At the same moment it reports how many distinct buffer slots were filled, then holds a busy flag for the whole internal write cycle. Two kinds of load are ignored: loads during the power-up lockout window, and loads during the internal write cycle. A load during the write cycle, or one that follows the previous load too closely, sets a sticky violation flag. A testbench can use the flag to judge a host-side controller.

The controller walks six states. LOCK is the power-up lockout. IDLE waits with an empty timer. ARMED has the load timer running. HELD has the timer stopped while write-enable is low. COMMIT lasts one cycle and issues the strobe. PROG is the internal write cycle.

The transitions are:
- LOCK→IDLE when the lockout count ends.
- IDLE→ARMED on a qualified load.
- ARMED→HELD on a falling write-enable.
- ARMED→ARMED (restart) on a qualified load.
- ARMED→COMMIT on timer expiry.
- HELD→ARMED on any rising write-enable.
- COMMIT→PROG unconditionally.
- PROG→IDLE when the write-cycle count ends.

All durations are parameters counted in clock cycles.

Top module: `eewr_ctrl`

## Requirements
- R1: After reset, `lockout` is high, and `busy`, `commit` and `violation` are low, for INIT_CYC cycles. Loads in that window change no buffer slot, start no timer and set no violation.
- R2: A write-enable low pulse counts as a byte load only if `we_n` was sampled low, with `ce_n` low, for at least MIN_PULSE_CYC consecutive cycles. A shorter pulse captures nothing and starts no commit.
- R3: A qualified rising edge of `we_n` with `ce_n` low stores `din` in the slot `addr[OFF_W-1:0]`. That slot is then readable on `rd_data` through `rd_idx`. `addr[ADDR_W-1:OFF_W]` of the latest load appears on `commit_page`.
- R4: Each qualified load restarts the load timer. With no falling `we_n` in between, `commit` rises BLC_CYC cycles after the timer starts. This is BLC_CYC+2 cycles after the input rise, because of the two-stage input sampling.
- R5: A falling `we_n` with `ce_n` low stops the timer, however long `we_n` stays low. The next rising edge restarts the full BLC_CYC period.
- R6: `commit` lasts exactly one cycle. `commit_cnt` gives the number of distinct slots loaded. Loading an already-filled slot overwrites its data without raising the count.
- R7: `busy` is high from the `commit` cycle through the following WC_CYC cycles, then falls.
- R8: A qualified load while `busy` is high sets `violation`. It leaves the buffer unchanged and starts no timer.
- R9: A qualified load whose rising edge comes fewer than MIN_GAP_CYC cycles after the previous accepted load sets `violation`. The byte is still stored.
- R10: `violation` stays high once set, until reset.
- R11: The first load accepted from IDLE clears all slots before storing its byte, so `commit_cnt` starts again at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; the low OFF_W bits select a buffer slot |
| din | input | DATA_W | Data byte to load |
| rd_idx | input | OFF_W | Buffer slot to read |
| rd_data | output | DATA_W | Content of slot `rd_idx` |
| lockout | output | 1 | Power-up write lockout active |
| busy | output | 1 | Commit or internal write cycle in progress |
| commit | output | 1 | One-cycle strobe when the load timer expires |
| commit_cnt | output | $clog2(2**OFF_W+1) | Distinct slots currently buffered |
| commit_page | output | ADDR_W-OFF_W | Page bits of the latest accepted load |
| violation | output | 1 | Sticky flag for loads while busy or spaced too closely |

## Verification
The assertions assume that `ce_n` stays low for the whole of each write-enable pulse. They also assume that `addr` and `din` are stable from the falling edge until after the rising edge, so the two-stage sampled bus lines up with the sampled strobe. The bench drives every input on the falling clock edge and sets address and data together with the falling write-enable. It holds them until the next pulse and keeps chip-enable low once writing begins. Pulse lengths are whole clock cycles, so qualification is decided exactly at the MIN_PULSE_CYC boundary.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
    typedef enum logic [2:0] {
        ST_LOCK,
        ST_IDLE,
        ST_ARMED,
        ST_HELD,
        ST_COMMIT,
        ST_PROG
    } eewr_state_e;
endpackage

// File: rtl/eewr_sync.sv
// Two-stage sampler for the asynchronous pin bundle.
module eewr_sync #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/eewr_we_filter.sv
// Edge detection and minimum-width qualification of the write strobe.
module eewr_we_filter #(
    parameter int MIN_PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_s,
    input  logic we_n_s,
    output logic ld_ok,
    output logic rise_any,
    output logic fall
);
    localparam int LW = $clog2(MIN_PULSE_CYC + 1);
    localparam logic [LW-1:0] LOW_SAT = LW'(MIN_PULSE_CYC);

    logic          we_q;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            we_q <= we_n_s;
            if (we_n_s || ce_n_s)
                low_cnt <= '0;
            else if (low_cnt != LOW_SAT)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rise_any = we_n_s & ~we_q & ~ce_n_s;
    assign fall     = ~we_n_s & we_q & ~ce_n_s;
    assign ld_ok    = rise_any & (low_cnt == LOW_SAT);

    // R2: a qualified load always follows a sampled low level
    p_ld_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok |-> $past(!we_n_s));
endmodule

// File: rtl/eewr_page_buf.sv
// Page buffer with per-slot fill bits and a filled-slot count.
module eewr_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr,
    input  logic [OFF_W-1:0]              wr_off,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [OFF_W-1:0]              rd_off,
    output logic [DATA_W-1:0]             rd_data,
    output logic [$clog2((1<<OFF_W)+1)-1:0] fill_cnt
);
    localparam int DEPTH = 1 << OFF_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0]  slot_vld;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              v_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (wr && (wr_off == OFF_W'(g))) begin
                d_q <= wr_data;
                v_q <= 1'b1;
            end else if (clr) begin
                d_q <= '0;
                v_q <= 1'b0;
            end
        end

        assign slot_data[g] = d_q;
        assign slot_vld[g]  = v_q;
    end

    assign rd_data = slot_data[rd_off];

    always_comb begin
        fill_cnt = '0;
        for (int i = 0; i < DEPTH; i++)
            fill_cnt = fill_cnt + CNT_W'(slot_vld[i]);
    end

    // R6: the count never exceeds the page size
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    // R11: a clear leaves at most the byte written alongside it
    p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill_cnt <= CNT_W'(1)));
endmodule

// File: rtl/eewr_seq.sv
// Sequencer: lockout, load timer, commit, write cycle and violation tracking.
module eewr_seq
    import eewr_pkg::*;
#(
    parameter int BLC_CYC     = 10000,
    parameter int WC_CYC      = 1000000,
    parameter int INIT_CYC    = 1000000,
    parameter int MIN_GAP_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_ok,
    input  logic rise_any,
    input  logic fall,
    output logic lockout,
    output logic busy,
    output logic commit,
    output logic buf_wr,
    output logic buf_clr,
    output logic violation
);
    localparam int T1   = (BLC_CYC > WC_CYC) ? BLC_CYC : WC_CYC;
    localparam int TMAX = (T1 > INIT_CYC) ? T1 : INIT_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int GW   = $clog2(MIN_GAP_CYC + 1);
    localparam logic [TW-1:0] INIT_LAST = TW'(INIT_CYC - 1);
    localparam logic [TW-1:0] BLC_LAST  = TW'(BLC_CYC - 1);
    localparam logic [TW-1:0] WC_LAST   = TW'(WC_CYC - 1);
    localparam logic [GW-1:0] GAP_SAT   = GW'(MIN_GAP_CYC);

    eewr_state_e   state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic [GW-1:0] gap_q;
    logic          tmr_clr;
    logic          tmr_run;
    logic          late_ld;
    logic          close_ld;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCK:   if (tmr_q == INIT_LAST) state_d = ST_IDLE;
            ST_IDLE:   if (ld_ok) state_d = ST_ARMED;
            ST_ARMED:  if (fall) state_d = ST_HELD;
                       else if (!ld_ok && tmr_q == BLC_LAST) state_d = ST_COMMIT;
            ST_HELD:   if (rise_any) state_d = ST_ARMED;
            ST_COMMIT: state_d = ST_PROG;
            ST_PROG:   if (tmr_q == WC_LAST) state_d = ST_IDLE;
            default:   state_d = ST_LOCK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCK;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        lockout = (state_q == ST_LOCK);
        busy    = (state_q == ST_COMMIT) || (state_q == ST_PROG);
        commit  = (state_q == ST_COMMIT);
        buf_wr  = ld_ok && ((state_q == ST_IDLE) || (state_q == ST_ARMED) ||
                            (state_q == ST_HELD));
        buf_clr = ld_ok && (state_q == ST_IDLE);
    end

    assign tmr_clr = (state_d != state_q) || ((state_q == ST_ARMED) && ld_ok);
    assign tmr_run = (state_q == ST_LOCK) || (state_q == ST_ARMED) || (state_q == ST_PROG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tmr_q <= '0;
        else if (tmr_clr) tmr_q <= '0;
        else if (tmr_run) tmr_q <= tmr_q + 1'b1;
    end

    // spacing between accepted loads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= GAP_SAT;
        else if (buf_wr)         gap_q <= GW'(1);
        else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
    end

    assign late_ld  = ld_ok && busy;
    assign close_ld = buf_wr && (gap_q < GAP_SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    violation <= 1'b0;
        else if (late_ld || close_ld)  violation <= 1'b1;
    end

    // R6: strobe lasts a single cycle
    p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R4: commit is only reached from a running timer
    p_commit_from_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state_q) == ST_ARMED);
    // R4: timer never runs past its limit
    p_tmr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (tmr_q < TW'(BLC_CYC)));
    // R10: violation is sticky
    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    // R1: lockout keeps everything quiet
    p_lock_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> (!busy && !buf_wr && !violation));
    // R7: busy ends only after the full write cycle
    p_prog_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tmr_q) == WC_LAST);
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl #(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int OFF_W         = 6,
    parameter int MIN_PULSE_CYC = 2,
    parameter int MIN_GAP_CYC   = 10,
    parameter int BLC_CYC       = 10000,
    parameter int WC_CYC        = 1000000,
    parameter int INIT_CYC      = 1000000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ce_n,
    input  logic                              we_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 din,
    input  logic [OFF_W-1:0]                  rd_idx,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              lockout,
    output logic                              busy,
    output logic                              commit,
    output logic [$clog2((1<<OFF_W)+1)-1:0]   commit_cnt,
    output logic [ADDR_W-OFF_W-1:0]           commit_page,
    output logic                              violation
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int SW     = 2 + ADDR_W + DATA_W;
    localparam logic [SW-1:0] SYNC_RST = {2'b11, {(SW-2){1'b0}}};

    logic [SW-1:0]     pins_s;
    logic              ce_n_s, we_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              ld_ok, rise_any, fall;
    logic              buf_wr, buf_clr;
    logic [PAGE_W-1:0] page_q;

    eewr_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, addr, din}),
        .q     (pins_s)
    );

    assign {ce_n_s, we_n_s, addr_s, din_s} = pins_s;

    eewr_we_filter #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_s   (ce_n_s),
        .we_n_s   (we_n_s),
        .ld_ok    (ld_ok),
        .rise_any (rise_any),
        .fall     (fall)
    );

    eewr_seq #(
        .BLC_CYC     (BLC_CYC),
        .WC_CYC      (WC_CYC),
        .INIT_CYC    (INIT_CYC),
        .MIN_GAP_CYC (MIN_GAP_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_ok     (ld_ok),
        .rise_any  (rise_any),
        .fall      (fall),
        .lockout   (lockout),
        .busy      (busy),
        .commit    (commit),
        .buf_wr    (buf_wr),
        .buf_clr   (buf_clr),
        .violation (violation)
    );

    eewr_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr       (buf_wr),
        .wr_off   (addr_s[OFF_W-1:0]),
        .wr_data  (din_s),
        .rd_off   (rd_idx),
        .rd_data  (rd_data),
        .fill_cnt (commit_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      page_q <= '0;
        else if (buf_wr) page_q <= addr_s[ADDR_W-1:OFF_W];
    end

    assign commit_page = page_q;

    // R8: nothing is stored while the write cycle runs
    p_busy_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(commit_cnt) || !$past(busy) || busy == 1'b0);
endmodule

// File: tb/eewr_ctrl_tb.sv
module eewr_ctrl_tb;
    localparam int BLC  = 200;
    localparam int WC   = 500;
    localparam int INIT = 300;
    localparam int GAP  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [5:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        lockout, busy, commit, violation;
    logic [6:0]  commit_cnt;
    logic [8:0]  commit_page;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_commit = 0;
    int last_commit_cyc = 0;
    bit done = 0;

    eewr_ctrl #(
        .MIN_PULSE_CYC(2), .MIN_GAP_CYC(GAP), .BLC_CYC(BLC),
        .WC_CYC(WC), .INIT_CYC(INIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .din(din), .rd_idx(rd_idx), .rd_data(rd_data), .lockout(lockout),
        .busy(busy), .commit(commit), .commit_cnt(commit_cnt),
        .commit_page(commit_page), .violation(violation)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (commit) begin
            n_commit = n_commit + 1;
            last_commit_cyc = cyc;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input longint act,
                           input longint lo, input longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // one write-enable pulse: lo cycles low, then hi cycles high; returns rise cycle
    task automatic pulse(input logic [8:0] pg, input logic [5:0] off, input logic [7:0] d,
                         input int lo, input int hi, output int rise_cyc);
        @(negedge clk);
        addr = {pg, off};
        din  = d;
        we_n = 1'b0;
        repeat (lo) @(negedge clk);
        we_n = 1'b1;
        rise_cyc = cyc;
        repeat (hi) @(negedge clk);
    endtask

    task automatic wait_commit(input int limit);
        int start = n_commit;
        for (int i = 0; i < limit && n_commit == start; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < WC + 50 && busy; i++) @(negedge clk);
    endtask

    task automatic read_slot(input logic [5:0] idx, output logic [7:0] val);
        @(negedge clk);
        rd_idx = idx;
        @(negedge clk);
        val = rd_data;
    endtask

    task automatic t_lock();
        int r, c0, n0;
        logic [7:0] v;
        @(negedge clk);
        chk("R1", "lockout after reset", lockout, 1);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "violation after reset", violation, 0);
        c0 = cyc;
        ce_n = 1'b0;
        pulse(9'h003, 6'd3, 8'h5A, 3, 12, r);
        for (int i = 0; i < INIT + 20 && lockout; i++) @(negedge clk);
        chk_rng("R1", "lockout length", cyc - c0, INIT - 20, INIT + 3);
        read_slot(6'd3, v);
        chk("R1", "slot after lockout load", v, 0);
        chk("R1", "count after lockout load", commit_cnt, 0);
        n0 = n_commit;
        repeat (BLC + 20) @(negedge clk);
        chk("R1", "no commit from lockout load", n_commit - n0, 0);
        chk("R1", "no violation from lockout load", violation, 0);
    endtask

    task automatic t_short();
        int r, n0;
        n0 = n_commit;
        pulse(9'h007, 6'd7, 8'h11, 1, 12, r);
        repeat (BLC + 20) @(negedge clk);
        chk("R2", "short pulse starts no commit", n_commit - n0, 0);
        chk("R2", "short pulse stores nothing", commit_cnt, 0);
    endtask

    task automatic t_page();
        int r, n0;
        logic [7:0] v;
        n0 = n_commit;
        pulse(9'h029, 6'd2, 8'hA1, 2, 15, r);
        pulse(9'h029, 6'd9, 8'hB2, 3, 15, r);
        pulse(9'h029, 6'd2, 8'hC3, 4, 15, r);
        chk("R6", "count with repeated slot", commit_cnt, 2);
        read_slot(6'd2, v);
        chk("R3", "overwritten slot data", v, 8'hC3);
        read_slot(6'd9, v);
        chk("R3", "slot 9 data", v, 8'hB2);
        wait_commit(BLC + 50);
        chk("R6", "single commit strobe", n_commit - n0, 1);
        chk_rng("R4", "commit delay after last rise", last_commit_cyc - r, BLC + 2, BLC + 6);
        chk("R3", "commit page", commit_page, 9'h029);
        chk("R7", "busy after commit", busy, 1);
        chk("R9", "well spaced loads no violation", violation, 0);
        wait_idle();
        chk_rng("R7", "busy length", cyc - last_commit_cyc, WC - 2, WC + 3);
    endtask

    task automatic t_hold();
        int r, n0;
        logic [7:0] v;
        n0 = n_commit;
        pulse(9'h001, 6'd4, 8'h44, 3, 15, r);
        chk("R11", "buffer cleared on new load", commit_cnt, 1);
        @(negedge clk);
        addr = {9'h001, 6'd4};
        din  = 8'h45;
        we_n = 1'b0;
        repeat (BLC + 60) @(negedge clk);
        chk("R5", "held strobe stops timer", n_commit - n0, 0);
        we_n = 1'b1;
        r = cyc;
        wait_commit(BLC + 50);
        chk_rng("R5", "restart delay", last_commit_cyc - r, BLC + 2, BLC + 6);
        read_slot(6'd4, v);
        chk("R5", "held load captured", v, 8'h45);
        chk("R6", "count after overwrite", commit_cnt, 1);
        wait_idle();
    endtask

    task automatic t_busy();
        int r, n0;
        logic [7:0] v;
        pulse(9'h002, 6'd0, 8'h10, 3, 15, r);
        wait_commit(BLC + 50);
        pulse(9'h002, 6'd1, 8'hEE, 3, 15, r);
        chk("R8", "violation on busy load", violation, 1);
        read_slot(6'd1, v);
        chk("R8", "busy load not stored", v, 0);
        chk("R8", "count unchanged", commit_cnt, 1);
        wait_idle();
        n0 = n_commit;
        repeat (BLC + 20) @(negedge clk);
        chk("R8", "busy load starts no timer", n_commit - n0, 0);
        chk("R10", "violation sticky", violation, 1);
    endtask

    task automatic t_gap();
        int r;
        pulse(9'h003, 6'd0, 8'h01, 3, 2, r);
        pulse(9'h003, 6'd1, 8'h02, 3, 15, r);
        chk("R9", "close loads set violation", violation, 1);
        chk("R9", "close load still stored", commit_cnt, 2);
        wait_commit(BLC + 50);
        wait_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_lock();
        t_short();
        t_page();
        t_hold();
        t_busy();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "violation cleared by reset", violation, 0);
        chk("R1", "lockout after second reset", lockout, 1);
        for (int i = 0; i < INIT + 20 && lockout; i++) @(negedge clk);
        t_gap();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule